// File: doc/BRIEF.md
# Data-Strobe Serial Receiver with Clock-Domain Resynchronisation

This block receives a two-wire data-strobe line. In this encoding exactly one of the two wires changes for every transmitted bit, so the XOR of the wires toggles once per bit. The block samples both wires with a fast line-side clock and treats each change of that XOR as a recovered bit clock edge. On each such edge it takes the level of the data wire as the bit.

Recovered bits are gathered into pairs. The first bit after the line goes quiet lands on lane 0. Each complete pair is written into a small asynchronous FIFO with Gray-coded pointers. On the local system clock side, pairs are popped and presented to the link as two parallel lanes with a one-cycle valid strobe. A rate input chooses the link pacing. Full rate may deliver a pair on every system clock cycle. Half rate delivers at most one pair every second cycle, which models a link clock at half the system clock.

Top module: `ds_rx_resync`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after it, `pair_valid` is 0, `lane0` and `lane1` are 0, and `overflow` is 0.
- R2: Every change of (`ds_data` XOR `ds_strobe`), provided it is held for at least one `clk_line` cycle, yields exactly one recovered bit. The bit equals the new level of `ds_data`.
- R3: Of two consecutive recovered bits forming a pair, the earlier one appears on `lane0` and the later one on `lane1`. The first bit after idle always starts a new pair.
- R4: Pairs reach the link in the order they were received. Each `pair_valid` cycle carries a complete pair that has not been delivered before.
- R5: If no bit arrives for `IDLE_CYCLES` consecutive `clk_line` cycles while a lone bit waits for its partner, that lone bit is discarded and never delivered.
- R6: With `mode_full` = 1, a non-empty FIFO is drained on every `clk_sys` cycle, so `pair_valid` can be high on consecutive cycles.
- R7: With `mode_full` = 0, `pair_valid` is never high on two consecutive `clk_sys` cycles.
- R8: A pair completed while the FIFO already holds `FIFO_DEPTH` pairs is dropped, and `overflow` rises. Once high, `overflow` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_line | input | 1 | Oversampling clock for the line wires |
| clk_sys | input | 1 | Local system clock of the link side |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| mode_full | input | 1 | 1 = full-rate pacing, 0 = half-rate pacing |
| ds_data | input | 1 | Encoded data wire |
| ds_strobe | input | 1 | Encoded strobe wire |
| lane0 | output | 1 | Earlier bit of the delivered pair |
| lane1 | output | 1 | Later bit of the delivered pair |
| pair_valid | output | 1 | High for one cycle per delivered pair |
| overflow | output | 1 | Sticky flag: a pair was dropped at the FIFO (system domain) |

## Verification
A wrong bit-pair phase shows at the ports as swapped lanes on the very next delivered pair. A lost or extra pair shifts every later pair, so the comparison against the expected stream flags it within one burst. A pointer or flag fault in the FIFO shows up either as repeated or missing pairs a few system cycles after the crossing latency, or as a valid strobe that breaks the half-rate spacing. An overflow flag that fails to rise or to hold is seen as soon as the synchroniser delay has passed after a deliberate over-fill.

// File: rtl/ds_rx_pkg.sv
`timescale 1ns/1ps
package ds_rx_pkg;
   typedef struct packed {
      logic lane1;
      logic lane0;
   } ds_pair_t;

   localparam int PAIR_W = $bits(ds_pair_t);
endpackage

// File: rtl/ds_sync_chain.sv
`timescale 1ns/1ps
module ds_sync_chain #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ds_sync_chain: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ds_edge_decoder.sv
`timescale 1ns/1ps
module ds_edge_decoder #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_line,
   input  logic rst_n,
   input  logic ds_data_i,
   input  logic ds_strobe_i,
   output logic bit_vld_o,
   output logic bit_o
);
   logic [1:0] wires_q;
   logic       xor_now;
   logic       xor_prev;

   ds_sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_wire_sync (
      .clk   (clk_line),
      .rst_n (rst_n),
      .d_i   ({ds_data_i, ds_strobe_i}),
      .q_o   (wires_q)
   );

   assign xor_now = wires_q[1] ^ wires_q[0];

   always_ff @(posedge clk_line or negedge rst_n) begin
      if (!rst_n) begin
         xor_prev  <= 1'b0;
         bit_vld_o <= 1'b0;
         bit_o     <= 1'b0;
      end else begin
         xor_prev  <= xor_now;
         bit_vld_o <= xor_now ^ xor_prev;
         bit_o     <= wires_q[1];
      end
   end
endmodule

// File: rtl/ds_pair_assembler.sv
`timescale 1ns/1ps
module ds_pair_assembler
   import ds_rx_pkg::*;
#(
   parameter int IDLE_CYCLES = 12
) (
   input  logic     clk_line,
   input  logic     rst_n,
   input  logic     bit_vld_i,
   input  logic     bit_i,
   output logic     pair_vld_o,
   output ds_pair_t pair_o
);
   localparam int IW = $clog2(IDLE_CYCLES + 1);
   localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYCLES - 1);

   if (IDLE_CYCLES < 2) begin : g_bad_idle
      $error("ds_pair_assembler: IDLE_CYCLES must be at least 2");
   end

   logic          have_half;
   logic          first_bit;
   logic [IW-1:0] idle_cnt;

   always_ff @(posedge clk_line or negedge rst_n) begin
      if (!rst_n) begin
         have_half  <= 1'b0;
         first_bit  <= 1'b0;
         idle_cnt   <= '0;
         pair_vld_o <= 1'b0;
         pair_o     <= '0;
      end else if (bit_vld_i) begin
         idle_cnt <= '0;
         if (have_half) begin
            pair_vld_o   <= 1'b1;
            pair_o.lane0 <= first_bit;
            pair_o.lane1 <= bit_i;
            have_half    <= 1'b0;
         end else begin
            pair_vld_o <= 1'b0;
            first_bit  <= bit_i;
            have_half  <= 1'b1;
         end
      end else begin
         pair_vld_o <= 1'b0;
         if (have_half) begin
            if (idle_cnt == IDLE_LAST) begin
               have_half <= 1'b0;
               idle_cnt  <= '0;
            end else begin
               idle_cnt <= idle_cnt + 1'b1;
            end
         end
      end
   end

   AST_PAIR_NEEDS_BIT: assert property (@(posedge clk_line) disable iff (!rst_n)
      pair_vld_o |-> $past(bit_vld_i)); // R3
endmodule

// File: rtl/ds_async_fifo.sv
`timescale 1ns/1ps
module ds_async_fifo #(
   parameter int DEPTH       = 4,
   parameter int WIDTH       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wclk,
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             wr_vld_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic             ovf_o,
   input  logic             rd_en_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             empty_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("ds_async_fifo: DEPTH must be a power of two, at least 2");
   end

   function automatic logic [AW:0] to_gray(input logic [AW:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [AW:0] from_gray(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0] wbin, wgray, rbin, rgray;
   logic [AW:0] rgray_w, wgray_r, rbin_w, wbin_nx, rbin_nx;
   logic        full_w, do_wr;

   // write side
   ds_sync_chain #(.WIDTH(AW + 1), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk (wclk), .rst_n (rst_n), .d_i (rgray), .q_o (rgray_w)
   );
   assign rbin_w  = from_gray(rgray_w);
   assign full_w  = (wbin - rbin_w) == FULL_CNT;
   assign do_wr   = wr_vld_i && !full_w;
   assign wbin_nx = wbin + 1'b1;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         ovf_o <= 1'b0;
      end else begin
         if (do_wr) begin
            wbin  <= wbin_nx;
            wgray <= to_gray(wbin_nx);
         end
         if (wr_vld_i && full_w) ovf_o <= 1'b1;
      end
   end

   always_ff @(posedge wclk) begin
      if (do_wr) mem[wbin[AW-1:0]] <= wr_data_i;
   end

   // read side
   ds_sync_chain #(.WIDTH(AW + 1), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk (rclk), .rst_n (rst_n), .d_i (wgray), .q_o (wgray_r)
   );
   assign empty_o   = rgray == wgray_r;
   assign rbin_nx   = rbin + 1'b1;
   assign rd_data_o = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_en_i && !empty_o) begin
         rbin  <= rbin_nx;
         rgray <= to_gray(rbin_nx);
      end
   end

   AST_OCCUPANCY_BOUND: assert property (@(posedge wclk) disable iff (!rst_n)
      (wbin - rbin_w) <= FULL_CNT); // R8
   AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!rst_n)
      ovf_o |=> ovf_o); // R8
endmodule

// File: rtl/ds_rx_resync.sv
`timescale 1ns/1ps
module ds_rx_resync
   import ds_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FIFO_DEPTH  = 4,
   parameter int IDLE_CYCLES = 12
) (
   input  logic clk_line,
   input  logic clk_sys,
   input  logic rst_n,
   input  logic mode_full,
   input  logic ds_data,
   input  logic ds_strobe,
   output logic lane0,
   output logic lane1,
   output logic pair_valid,
   output logic overflow
);
   logic            bit_vld, bit_val;
   logic            asm_vld;
   ds_pair_t        asm_pair;
   logic            ovf_line;
   logic            fifo_empty;
   logic [PAIR_W-1:0] fifo_rd;
   ds_pair_t        rd_pair;
   logic            pace_phase;
   logic            pop;

   ds_edge_decoder #(.SYNC_STAGES(SYNC_STAGES)) u_decode (
      .clk_line    (clk_line),
      .rst_n       (rst_n),
      .ds_data_i   (ds_data),
      .ds_strobe_i (ds_strobe),
      .bit_vld_o   (bit_vld),
      .bit_o       (bit_val)
   );

   ds_pair_assembler #(.IDLE_CYCLES(IDLE_CYCLES)) u_pair (
      .clk_line   (clk_line),
      .rst_n      (rst_n),
      .bit_vld_i  (bit_vld),
      .bit_i      (bit_val),
      .pair_vld_o (asm_vld),
      .pair_o     (asm_pair)
   );

   ds_async_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(PAIR_W), .SYNC_STAGES(SYNC_STAGES)) u_cross (
      .wclk      (clk_line),
      .rclk      (clk_sys),
      .rst_n     (rst_n),
      .wr_vld_i  (asm_vld),
      .wr_data_i (asm_pair),
      .ovf_o     (ovf_line),
      .rd_en_i   (pop),
      .rd_data_o (fifo_rd),
      .empty_o   (fifo_empty)
   );

   ds_sync_chain #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ovf_sync (
      .clk (clk_sys), .rst_n (rst_n), .d_i (ovf_line), .q_o (overflow)
   );

   assign rd_pair = ds_pair_t'(fifo_rd);
   assign pop     = !fifo_empty && (mode_full || pace_phase);

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         pace_phase <= 1'b0;
         pair_valid <= 1'b0;
         lane0      <= 1'b0;
         lane1      <= 1'b0;
      end else begin
         pace_phase <= ~pace_phase;
         pair_valid <= pop;
         if (pop) begin
            lane0 <= rd_pair.lane0;
            lane1 <= rd_pair.lane1;
         end
      end
   end

   AST_HALF_RATE_GAP: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (pair_valid && $past(pair_valid)) |-> ($past(mode_full) || $past(mode_full, 2))); // R7
   AST_VALID_FROM_FIFO: assert property (@(posedge clk_sys) disable iff (!rst_n)
      pair_valid |-> $past(!fifo_empty)); // R4
endmodule

// File: tb/ds_rx_resync_tb_top.sv
`timescale 1ns/1ps
module ds_rx_resync_tb_top;
   logic clk_line = 1'b0;
   logic clk_sys  = 1'b0;
   logic rst_n, mode_full, ds_data, ds_strobe;
   logic lane0, lane1, pair_valid, overflow;

   int n_cmp = 0;
   int n_bad = 0;
   logic [1:0] rxq [$];
   int half_viol = 0;
   int full_b2b  = 0;
   logic v_prev = 1'b0, m1 = 1'b0, m2 = 1'b0;

   always #5  clk_line = ~clk_line;
   always #10 clk_sys  = ~clk_sys;

   ds_rx_resync dut_i (
      .clk_line (clk_line), .clk_sys (clk_sys), .rst_n (rst_n),
      .mode_full (mode_full), .ds_data (ds_data), .ds_strobe (ds_strobe),
      .lane0 (lane0), .lane1 (lane1), .pair_valid (pair_valid), .overflow (overflow)
   );

   // {mode[15], per[14:12], nbits[11:8], bits[7:0]} ; bit 0 is sent first
   localparam logic [15:0] VEC [6] = '{
      {1'b1, 3'd4, 4'd8, 8'hB2},
      {1'b0, 3'd4, 4'd8, 8'hC5},
      {1'b1, 3'd2, 4'd6, 8'h2D},
      {1'b1, 3'd3, 4'd5, 8'h13},   // odd: trailing bit dropped (R5)
      {1'b0, 3'd2, 4'd7, 8'h6A},   // odd again
      {1'b1, 3'd4, 4'd2, 8'h02}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, input int per);
      @(negedge clk_line);
      if (b != ds_data) ds_data = b;
      else              ds_strobe = ~ds_strobe;
      repeat (per - 1) @(negedge clk_line);
   endtask

   always @(negedge clk_sys) begin
      if (rst_n) begin
         if (pair_valid) rxq.push_back({lane0, lane1});
         if (pair_valid && v_prev && !m1 && !m2) half_viol++;
         if (pair_valid && v_prev && m1 && m2)   full_b2b++;
      end
      v_prev <= pair_valid;
      m2 <= m1;
      m1 <= mode_full;
   end

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; mode_full = 1'b1; ds_data = 1'b0; ds_strobe = 1'b0;
      repeat (4) @(negedge clk_sys);
      chk("R1 valid in reset", {7'd0, pair_valid}, 8'd0);
      chk("R1 lanes in reset", {6'd0, lane1, lane0}, 8'd0);
      chk("R1 overflow in reset", {7'd0, overflow}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk_sys);
      chk("R1 valid after release", {7'd0, pair_valid}, 8'd0);
      repeat (4) @(negedge clk_sys);

      // table walk: R2 R3 R4 R5 R7
      for (int v = 0; v < 6; v++) begin
         logic [15:0] e;
         int np;
         e = VEC[v];
         mode_full = e[15];
         rxq.delete();
         repeat (3) @(negedge clk_sys);
         for (int i = 0; i < int'(e[11:8]); i++) send_bit(e[i], int'(e[14:12]));
         repeat (40) @(negedge clk_sys);
         np = int'(e[11:8]) / 2;
         chk($sformatf("R4 R5 pair count vec%0d", v), 8'(rxq.size()), 8'(np));
         for (int p = 0; p < np; p++) begin
            logic [1:0] got;
            got = (p < rxq.size()) ? rxq[p] : 2'bxx;
            chk($sformatf("R2 R3 vec%0d pair%0d {lane0,lane1}", v, p),
                {6'd0, got}, {6'd0, e[2*p], e[2*p+1]});
         end
      end

      // over-fill in half-rate mode, then drain at full rate: R8 R6
      @(negedge clk_sys);
      mode_full = 1'b0;
      repeat (2) @(negedge clk_sys);
      for (int i = 0; i < 24; i++) send_bit(1'(i[0] ^ i[2]), 1);
      @(negedge clk_sys);
      full_b2b  = 0;
      mode_full = 1'b1;
      repeat (40) @(negedge clk_sys);
      chk("R8 overflow raised", {7'd0, overflow}, 8'd1);
      chk("R6 back-to-back at full rate", {7'd0, full_b2b != 0}, 8'd1);
      repeat (20) @(negedge clk_sys);
      chk("R8 overflow sticky", {7'd0, overflow}, 8'd1);
      chk("R7 no adjacent valids at half rate", 8'(half_viol), 8'd0);

      // reset clears everything: R1
      rst_n = 1'b0;
      @(negedge clk_line);
      ds_data = 1'b0; ds_strobe = 1'b0;
      repeat (3) @(negedge clk_sys);
      chk("R1 overflow cleared", {7'd0, overflow}, 8'd0);
      chk("R1 valid cleared", {7'd0, pair_valid}, 8'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk_sys);

      // after reset, first bit lands on lane0: R3
      rxq.delete();
      send_bit(1'b1, 3); send_bit(1'b0, 3); send_bit(1'b0, 3); send_bit(1'b1, 3);
      repeat (30) @(negedge clk_sys);
      chk("R3 post-reset count", 8'(rxq.size()), 8'd2);
      chk("R3 post-reset pair0", {6'd0, (rxq.size() > 0) ? rxq[0] : 2'bxx}, 8'b10);
      chk("R3 post-reset pair1", {6'd0, (rxq.size() > 1) ? rxq[1] : 2'bxx}, 8'b01);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule